// File: doc/BRIEF.md
# Dynamic Voltage Scaling Sleep Controller

This block is the power-state sequencer between a processor core and an external voltage regulator. It runs from the always-on oscillator clock. It takes idle and wake-up requests from the core, and software sets its mode through a small register write port. It decodes its state into a core clock enable, an oscillator enable and a `low_pwr_o` level that sets the regulator to reduced or nominal voltage.

There are four states. Awake runs the core. In big sleep the core clock is off and the oscillator keeps running. Deep sleep stops both. A ramp state follows deep sleep and waits for a programmable number of oscillator cycles, so that the regulator can settle before the core restarts.

When voltage scaling is enabled, an idle request goes to big sleep instead of deep sleep. In big sleep the regulator level follows a software min/max choice. That level is held through wake-up, so the core resumes at the voltage that was chosen.

Top module: `dvs_sleep_ctrl`

## Requirements
- R1: During and right after reset, the state is awake (code 0) with `core_clk_en_o`=1, `osc_en_o`=1 and `low_pwr_o`=0. All control bits and the ramp reload are 0.
- R2: A write to address 0 sets the control bits: bit 0 low-power enable, bit 4 deep-sleep allow, bit 10 scaling enable, bit 11 minimum-voltage select. A write to address 1 loads the ramp reload from the low `TMR_W` data bits. Both take effect from the following clock edge.
- R3: An idle request in awake moves the state to deep sleep (code 2) only if deep-sleep allow is 1 and scaling enable is 0. Otherwise it moves the state to big sleep (code 1).
- R4: A wake-up request in big sleep returns the state to awake on the next edge. In big sleep an idle request is ignored, and in awake a lone wake-up request is ignored.
- R5: When idle and wake-up are requested in the same cycle in awake, the wake-up request wins and the state stays awake.
- R6: `core_clk_en_o` is 1 only in awake. `osc_en_o` is 0 only in deep sleep, so it stays 1 in big sleep and in ramp (code 3).
- R7: While both low-power enable and scaling enable are 1, `low_pwr_o` takes the minimum-voltage select one edge after each cycle spent in big sleep. It holds its level in every other state, including after wake-up.
- R8: When low-power enable or scaling enable is 0, `low_pwr_o` is 0 from the next edge on, in every state.
- R9: A wake-up request in deep sleep moves the state to ramp and loads the reload value N. The state becomes awake exactly N+1 edges later. Idle and wake-up requests are ignored during ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 ramp reload |
| reg_wdata_i | input | DATA_W | Register write data |
| idle_req_i | input | 1 | Core is ready to sleep |
| wake_req_i | input | 1 | Core wake-up request |
| state_o | output | 2 | Current state: 0 awake, 1 big sleep, 2 deep sleep, 3 ramp |
| core_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| low_pwr_o | output | 1 | 1 selects reduced regulator voltage |

## Verification
The assertions assume that the requests and the write port are synchronous to `clk_i` and stable across each rising edge. They also assume that the clock keeps running in deep sleep, because the ramp counter depends on it. The stimulus changes all inputs just after a falling edge and holds them for a full cycle. It only writes registers between request patterns, except where a change of min/max select or of scaling enable inside big sleep or awake is the point of the test.

// File: rtl/dvs_sleep_pkg.sv
package dvs_sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_BIG   = 2'd1,
    ST_DEEP  = 2'd2,
    ST_RAMP  = 2'd3
  } pm_state_e;

  localparam int LP_EN_BIT   = 0;
  localparam int DEEP_OK_BIT = 4;
  localparam int DVS_BIT     = 10;
  localparam int MIN_BIT     = 11;

  typedef struct packed {
    logic lp_en;
    logic deep_ok;
    logic dvs_en;
    logic min_sel;
  } pm_ctrl_t;
endpackage

// File: rtl/dvs_sleep_regs.sv
module dvs_sleep_regs
  import dvs_sleep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output pm_ctrl_t          ctrl_o,
  output logic [TMR_W-1:0]  reload_o
);
  pm_ctrl_t         ctrl_q;
  logic [TMR_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (we_i) begin
      if (!addr_i) begin
        ctrl_q.lp_en   <= wdata_i[LP_EN_BIT];
        ctrl_q.deep_ok <= wdata_i[DEEP_OK_BIT];
        ctrl_q.dvs_en  <= wdata_i[DVS_BIT];
        ctrl_q.min_sel <= wdata_i[MIN_BIT];
      end else begin
        reload_q <= wdata_i[TMR_W-1:0];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> (ctrl_o.dvs_en == $past(wdata_i[DVS_BIT])
                           && ctrl_o.min_sel == $past(wdata_i[MIN_BIT])));
  p_reload_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i) |=> (reload_o == $past(wdata_i[TMR_W-1:0])));
endmodule

// File: rtl/dvs_setup_timer.sv
module dvs_setup_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  p_cnt_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && done_o) |=> done_o);
endmodule

// File: rtl/dvs_sleep_fsm.sv
module dvs_sleep_fsm
  import dvs_sleep_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pm_ctrl_t  ctrl_i,
  input  logic      idle_req_i,
  input  logic      wake_req_i,
  input  logic      tmr_done_i,
  output pm_state_e state_o,
  output logic      tmr_load_o,
  output logic      tmr_run_o,
  output logic      core_clk_en_o,
  output logic      osc_en_o,
  output logic      low_pwr_o
);
  pm_state_e st_q, st_d;
  logic      low_q, low_d;
  logic      lp_active;

  assign lp_active = ctrl_i.lp_en && ctrl_i.dvs_en;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_run_o  = 1'b0;
    unique case (st_q)
      ST_AWAKE: if (!wake_req_i && idle_req_i)
                  st_d = (ctrl_i.deep_ok && !ctrl_i.dvs_en) ? ST_DEEP : ST_BIG;
      ST_BIG:   if (wake_req_i) st_d = ST_AWAKE;
      ST_DEEP:  if (wake_req_i) begin
                  st_d       = ST_RAMP;
                  tmr_load_o = 1'b1;
                end
      ST_RAMP:  begin
                  tmr_run_o = 1'b1;
                  if (tmr_done_i) st_d = ST_AWAKE;
                end
      default:  st_d = ST_AWAKE;
    endcase
  end

  // level is captured in big sleep and held across wake-up
  always_comb begin
    low_d = low_q;
    if (!lp_active)         low_d = 1'b0;
    else if (st_q == ST_BIG) low_d = ctrl_i.min_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_AWAKE;
      low_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      low_q <= low_d;
    end
  end

  assign state_o       = st_q;
  assign core_clk_en_o = (st_q == ST_AWAKE);
  assign osc_en_o      = (st_q != ST_DEEP);
  assign low_pwr_o     = low_q;

  p_idle_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_AWAKE && idle_req_i && !wake_req_i && ctrl_i.dvs_en)
      |=> (st_q == ST_BIG));
  p_big_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIG && wake_req_i) |=> (st_q == ST_AWAKE));
  p_big_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIG && !wake_req_i) |=> (st_q == ST_BIG));
  p_wake_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_AWAKE && wake_req_i) |=> (st_q == ST_AWAKE));
  p_clk_needs_osc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o |-> osc_en_o);
  p_lp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_BIG && lp_active) |=> $stable(low_pwr_o));
  p_lp_forced_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_active |=> !low_pwr_o);
  p_deep_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEEP) |=> (st_q == ST_DEEP || st_q == ST_RAMP));
endmodule

// File: rtl/dvs_sleep_ctrl.sv
module dvs_sleep_ctrl
  import dvs_sleep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              idle_req_i,
  input  logic              wake_req_i,
  output logic [1:0]        state_o,
  output logic              core_clk_en_o,
  output logic              osc_en_o,
  output logic              low_pwr_o
);
  pm_ctrl_t         ctrl;
  logic [TMR_W-1:0] reload;
  logic             tmr_load, tmr_run, tmr_done;
  pm_state_e        st;

  dvs_sleep_regs #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .ctrl_o   (ctrl),
    .reload_o (reload)
  );

  dvs_setup_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i     (tmr_load),
    .load_val_i (reload),
    .run_i      (tmr_run),
    .done_o     (tmr_done)
  );

  dvs_sleep_fsm u_fsm (
    .clk_i, .rst_ni,
    .ctrl_i        (ctrl),
    .idle_req_i,
    .wake_req_i,
    .tmr_done_i    (tmr_done),
    .state_o       (st),
    .tmr_load_o    (tmr_load),
    .tmr_run_o     (tmr_run),
    .core_clk_en_o,
    .osc_en_o,
    .low_pwr_o
  );

  assign state_o = st;
endmodule

// File: tb/dvs_sleep_ctrl_test.sv
module dvs_sleep_ctrl_test;
  localparam int DATA_W = 16;
  localparam int TMR_W  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic idle = 1'b0, wake = 1'b0;
  logic [1:0] state;
  logic core_clk_en, osc_en, low_pwr;

  always #4 clk = ~clk;

  dvs_sleep_ctrl #(.DATA_W(DATA_W), .TMR_W(TMR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .idle_req_i(idle), .wake_req_i(wake),
    .state_o(state), .core_clk_en_o(core_clk_en),
    .osc_en_o(osc_en), .low_pwr_o(low_pwr)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference
  int m_st, m_cnt, m_low, m_reload;
  bit m_lp, m_deep, m_dvs, m_min;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_low = 0; m_reload = 0;
      m_lp = 0; m_deep = 0; m_dvs = 0; m_min = 0;
    end else begin
      int nst, ncnt, nlow;
      nst = m_st; ncnt = m_cnt; nlow = m_low;
      if (!(m_lp && m_dvs)) nlow = 0;
      else if (m_st == 1) nlow = m_min;
      case (m_st)
        0: if (idle && !wake) nst = (m_deep && !m_dvs) ? 2 : 1;
        1: if (wake) nst = 0;
        2: if (wake) begin nst = 3; ncnt = m_reload; end
        default: if (m_cnt == 0) nst = 0; else ncnt = m_cnt - 1;
      endcase
      if (reg_we) begin
        if (!reg_addr) begin
          m_lp = reg_wdata[0]; m_deep = reg_wdata[4];
          m_dvs = reg_wdata[10]; m_min = reg_wdata[11];
        end else m_reload = int'(reg_wdata[TMR_W-1:0]);
      end
      m_st = nst; m_cnt = ncnt; m_low = nlow;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R4 state vs model", int'(state), m_st);
    chk("R6 core_clk_en vs model", int'(core_clk_en), (m_st == 0) ? 1 : 0);
    chk("R6 osc_en vs model", int'(osc_en), (m_st == 2) ? 0 : 1);
    chk("R7 low_pwr vs model", int'(low_pwr), m_low);
  endtask

  task automatic wr(bit a, int d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = DATA_W'(d);
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", int'(state), 0);
    chk("R1 core_clk_en", int'(core_clk_en), 1);
    chk("R1 osc_en", int'(osc_en), 1);
    chk("R1 low_pwr", int'(low_pwr), 0);
    rst_ni = 1'b1;
    cyc();
    chk("R1 state after release", int'(state), 0);

    // R3 default: deep sleep blocked -> big sleep, R8 low stays 0
    idle = 1; cyc(); idle = 0;
    chk("R3 idle with deep blocked", int'(state), 1);
    cyc();
    chk("R8 low_pwr with scaling off", int'(low_pwr), 0);
    idle = 1; cyc(); idle = 0;
    chk("R4 idle ignored in big sleep", int'(state), 1);
    wake = 1; cyc(); wake = 0;
    chk("R4 wake from big sleep", int'(state), 0);
    wake = 1; cyc(); wake = 0;
    chk("R4 lone wake in awake", int'(state), 0);

    // R7 min select, held across wake
    wr(0, 'h0C01);
    idle = 1; cyc(); idle = 0;
    cyc();
    chk("R7 low_pwr follows min in big sleep", int'(low_pwr), 1);
    wake = 1; cyc(); wake = 0;
    chk("R7 low_pwr held after wake", int'(low_pwr), 1);
    repeat (3) cyc();
    chk("R7 low_pwr still held", int'(low_pwr), 1);

    // R5 simultaneous requests
    idle = 1; wake = 1; cyc(); idle = 0; wake = 0;
    chk("R5 wake wins", int'(state), 0);

    // R7 max select inside big sleep
    idle = 1; cyc(); idle = 0;
    wr(0, 'h0401);
    cyc();
    chk("R7 low_pwr follows max", int'(low_pwr), 0);
    wr(0, 'h0C01);
    cyc();
    chk("R7 low_pwr back to min", int'(low_pwr), 1);
    wake = 1; cyc(); wake = 0;
    // R8 scaling disabled while awake
    wr(0, 'h0801);
    cyc();
    chk("R8 low_pwr forced low", int'(low_pwr), 0);

    // R2/R9 deep sleep and ramp
    wr(1, 5);
    wr(0, 'h0010);
    idle = 1; cyc();
    chk("R3 idle enters deep sleep", int'(state), 2);
    chk("R6 osc off in deep", int'(osc_en), 0);
    cyc();
    chk("R4 idle ignored in deep sleep", int'(state), 2);
    wake = 1; cyc();
    chk("R9 wake enters ramp", int'(state), 3);
    chk("R6 osc on in ramp", int'(osc_en), 1);
    chk("R6 core clock off in ramp", int'(core_clk_en), 0);
    n = 0;
    while (state != 2'd0 && n < 50) begin cyc(); n++; end
    idle = 0; wake = 0;
    chk("R9 R2 ramp length for reload 5", n, 6);

    // R3 deep allowed but scaling on -> big sleep
    wr(0, 'h0410);
    idle = 1; cyc(); idle = 0;
    chk("R3 scaling overrides deep", int'(state), 1);
    wake = 1; cyc(); wake = 0;

    // R9 reload zero
    wr(0, 'h0010);
    wr(1, 0);
    idle = 1; cyc(); idle = 0;
    wake = 1; cyc(); wake = 0;
    chk("R9 ramp entered", int'(state), 3);
    cyc();
    chk("R9 reload 0 exits after one edge", int'(state), 0);
    repeat (2) cyc();
    finish_run();
  end
endmodule